// File: doc/BRIEF.md
# Two-Phase Conversion Sequencer

This block is the digital timing controller of a sampling converter that resolves each sample in two coarse 9-bit passes. A rising edge on an asynchronous start input launches a conversion. From one internal cycle counter the controller then drives the sample-and-hold control, a strobe for each pass, the hold of the residue stage, a one-cycle output-latch update and an active-low busy flag.

The first phase holds the input sampler and takes the coarse code. At the start of the second phase the residue stage goes into hold and the input sampler returns to track. Acquisition of the next sample therefore overlaps the fine pass and the correction, while busy stays low across both phases. The two pass codes come from outside the block, and each is captured in the cycle its strobe is high. When the latch updates, the controller merges the two codes into a 16-bit two's-complement word. A start edge that arrives during a conversion is dropped and sets a sticky overrun flag.

Top module: `conv_seq_ctrl`

## Requirements
- R1: While reset is applied and right after it, busy_n is 1, smp_hold, res_hold, p1_strobe, p2_strobe, latch_upd and overrun are 0, and result is 0.
- R2: start_async passes through two synchronizing flops before edge detection. Drive a rising edge just after a clock edge: busy_n goes low and smp_hold goes high after the third rising clock edge. A start level held high with no new edge never begins another conversion.
- R3: smp_hold is high for exactly PH1_CYC cycles. p1_strobe is high for one cycle, at cycle index P1_AT counted from 0 at the first hold cycle, and p1_code is captured in that cycle.
- R4: When phase one ends, smp_hold falls and res_hold rises in the same cycle. res_hold stays high for exactly PH2_CYC cycles, and busy_n stays low all that time. The sampler never holds while the residue stage holds.
- R5: p2_strobe is high for one cycle, at cycle index P2_AT of phase two, and p2_code is captured in that cycle.
- R6: latch_upd is high for one cycle, in the last cycle of phase two. result takes its new value at the clock edge that ends that cycle, and busy_n returns high at the same edge. busy_n is low for exactly PH1_CYC+PH2_CYC cycles.
- R7: With unsigned 9-bit codes c1 and c2, v = c1*128 + c2 - 128 is clamped to the range 0..65535. result is v with bit 15 inverted.
- R8: A start edge detected while busy_n is low changes neither the timing nor the result of the running conversion. It sets overrun, which stays 1 until reset.
- R9: result holds its value at every clock edge without latch_upd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_async | input | 1 | Asynchronous conversion start, rising edge |
| p1_code | input | 9 | First-pass coarse code |
| p2_code | input | 9 | Second-pass residue code |
| smp_hold | output | 1 | Input sampler hold (1) / track (0) |
| res_hold | output | 1 | Residue stage hold |
| p1_strobe | output | 1 | First-pass capture strobe |
| p2_strobe | output | 1 | Second-pass capture strobe |
| latch_upd | output | 1 | Output latch update pulse |
| busy_n | output | 1 | Low while converting |
| overrun | output | 1 | Sticky: start edge seen while busy |
| result | output | 16 | Corrected two's-complement result |

## Verification
An error in the phase counter shows at the ports within one conversion. The busy-low span or a hold span comes out at the wrong length, or a strobe lands at the wrong index. The pass-code stub drives valid codes only in the cycle its strobe is high, so a capture in the wrong cycle also corrupts the next result word. If the state register re-entered phase one on an ignored start edge, busy would stretch at the very next rise of busy_n, and the sticky overrun bit would show a missed set on the same conversion.

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl #(
  parameter int PH1_CYC = 438,
  parameter int PH2_CYC = 225,
  parameter int P1_AT   = 300,
  parameter int P2_AT   = 120,
  parameter int CODE_W  = 9,
  parameter int RES_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_async,
  input  logic [CODE_W-1:0] p1_code,
  input  logic [CODE_W-1:0] p2_code,
  output logic              smp_hold,
  output logic              res_hold,
  output logic              p1_strobe,
  output logic              p2_strobe,
  output logic              latch_upd,
  output logic              busy_n,
  output logic              overrun,
  output logic [RES_W-1:0]  result
);
  localparam int SHIFT  = RES_W - CODE_W;
  localparam int SUM_W  = RES_W + 2;
  localparam int MAXPH  = (PH1_CYC > PH2_CYC) ? PH1_CYC : PH2_CYC;
  localparam int CNT_W  = $clog2(MAXPH) + 1;
  localparam logic [SUM_W-1:0] OFFSET = SUM_W'(1) << (SHIFT);

  typedef enum logic [1:0] {S_IDLE, S_PH1, S_PH2} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       sync_q;
  logic [CODE_W-1:0] c1_q, c2_q;
  logic             edge_det, ph1_last, ph2_last;
  logic [SUM_W-1:0] sum;
  logic [RES_W-1:0] clamped;

  assign edge_det  = sync_q[1] & ~sync_q[2];
  assign ph1_last  = (cnt == CNT_W'(PH1_CYC - 1));
  assign ph2_last  = (cnt == CNT_W'(PH2_CYC - 1));

  assign busy_n    = (st == S_IDLE);
  assign smp_hold  = (st == S_PH1);
  assign res_hold  = (st == S_PH2);
  assign p1_strobe = (st == S_PH1) && (cnt == CNT_W'(P1_AT));
  assign p2_strobe = (st == S_PH2) && (cnt == CNT_W'(P2_AT));
  assign latch_upd = (st == S_PH2) && ph2_last;

  assign sum = {2'b00, c1_q, {SHIFT{1'b0}}}
             + {{(SUM_W-CODE_W){1'b0}}, c2_q} - OFFSET;

  always_comb begin
    if (sum[SUM_W-1])       clamped = '0;
    else if (sum[SUM_W-2])  clamped = '1;
    else                    clamped = sum[RES_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= '0;
      st      <= S_IDLE;
      cnt     <= '0;
      c1_q    <= '0;
      c2_q    <= '0;
      overrun <= 1'b0;
      result  <= '0;
    end else begin
      sync_q <= {sync_q[1:0], start_async};
      if (p1_strobe) c1_q <= p1_code;
      if (p2_strobe) c2_q <= p2_code;
      if (edge_det && st != S_IDLE) overrun <= 1'b1;
      case (st)
        S_IDLE: if (edge_det) begin
          st  <= S_PH1;
          cnt <= '0;
        end
        S_PH1: if (ph1_last) begin
          st  <= S_PH2;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        S_PH2: if (ph2_last) begin
          st     <= S_IDLE;
          cnt    <= '0;
          result <= clamped ^ (RES_W'(1) << (RES_W-1));
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/conv_seq_chk.sv
module conv_seq_chk #(
  parameter int PH1_CYC = 438,
  parameter int PH2_CYC = 225,
  parameter int RES_W   = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy_n,
  input logic             smp_hold,
  input logic             res_hold,
  input logic             p1_strobe,
  input logic             p2_strobe,
  input logic             latch_upd,
  input logic             overrun,
  input logic [RES_W-1:0] result
);
  localparam int TOT = PH1_CYC + PH2_CYC;
  localparam int BW  = $clog2(TOT) + 2;
  logic [BW-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (!rst_n)       bcnt <= '0;
    else if (!busy_n) bcnt <= bcnt + 1'b1;
    else              bcnt <= '0;
  end

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> busy_n && !overrun && !smp_hold); // R1
  AST_START_HOLD: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy_n) |-> smp_hold && !res_hold); // R2
  AST_HOLD_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(smp_hold && res_hold)); // R4
  AST_PH2_TRACK: assert property (@(posedge clk) disable iff (!rst_n) $fell(smp_hold) |-> res_hold && !busy_n); // R4
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({p1_strobe, p2_strobe, latch_upd})); // R3
  AST_LATCH_END: assert property (@(posedge clk) disable iff (!rst_n) latch_upd |=> busy_n); // R6
  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy_n) |-> bcnt == BW'(TOT)); // R6
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) overrun |=> overrun); // R8
  AST_RES_STABLE: assert property (@(posedge clk) disable iff (!rst_n) !latch_upd |=> $stable(result)); // R9
endmodule

bind conv_seq_ctrl conv_seq_chk #(.PH1_CYC(PH1_CYC), .PH2_CYC(PH2_CYC), .RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_n(busy_n), .smp_hold(smp_hold), .res_hold(res_hold),
  .p1_strobe(p1_strobe), .p2_strobe(p2_strobe), .latch_upd(latch_upd),
  .overrun(overrun), .result(result));

// File: tb/tb_conv_seq_ctrl.sv
module tb_conv_seq_ctrl;
  localparam int PH1 = 40, PH2 = 24, P1A = 30, P2A = 10;

  logic clk = 1'b0, rst_n = 1'b0, start_async = 1'b0;
  logic [8:0] p1_code = '0, p2_code = '0, stub_a = '0, stub_b = '0;
  logic smp_hold, res_hold, p1_strobe, p2_strobe, latch_upd, busy_n, overrun;
  logic [15:0] result;
  int n_run = 0, n_fail = 0;
  bit ovr_exp = 1'b0;

  always #4 clk = ~clk;

  conv_seq_ctrl #(.PH1_CYC(PH1), .PH2_CYC(PH2), .P1_AT(P1A), .P2_AT(P2A)) dut (
    .clk(clk), .rst_n(rst_n), .start_async(start_async), .p1_code(p1_code), .p2_code(p2_code),
    .smp_hold(smp_hold), .res_hold(res_hold), .p1_strobe(p1_strobe), .p2_strobe(p2_strobe),
    .latch_upd(latch_upd), .busy_n(busy_n), .overrun(overrun), .result(result));

  always @(negedge clk) begin
    p1_code <= p1_strobe ? stub_a : ~stub_a;
    p2_code <= p2_strobe ? stub_b : ~stub_b;
  end

  function automatic logic [15:0] exp_res(input logic [8:0] a, input logic [8:0] b);
    int v;
    v = int'(a) * 128 + int'(b) - 128;
    if (v < 0) v = 0;
    if (v > 65535) v = 65535;
    return 16'(v) ^ 16'h8000;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic convert(input logic [8:0] a, input logic [8:0] b, input bit poke, input bit keep);
    int k = 0, hc = 0, rc = 0, p1p = -1, p2p = -1, lp = -1, np = 0;
    @(negedge clk);
    stub_a = a; stub_b = b; start_async = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(busy_n == 1'b1, "R2 busy before 3rd edge", int'(busy_n), 1);
    @(negedge clk);
    chk(busy_n == 1'b0 && smp_hold, "R2 busy after 3rd edge", int'(busy_n), 0);
    while (!busy_n && k < 4 * (PH1 + PH2)) begin
      if (smp_hold) hc++;
      if (res_hold) rc++;
      if (p1_strobe) begin p1p = k; np++; end
      if (p2_strobe) begin p2p = k; np++; end
      if (latch_upd) lp = k;
      if (k == 2 && !keep) start_async = 1'b0;
      if (poke && k == 10) start_async = 1'b1;
      if (poke && k == 14) start_async = 1'b0;
      k++;
      @(negedge clk);
    end
    if (poke) ovr_exp = 1'b1;
    chk(k == PH1 + PH2, "R6 busy span", k, PH1 + PH2);
    chk(hc == PH1, "R3 hold span", hc, PH1);
    chk(p1p == P1A, "R3 p1 strobe index", p1p, P1A);
    chk(rc == PH2, "R4 residue hold span", rc, PH2);
    chk(p2p == PH1 + P2A, "R5 p2 strobe index", p2p, PH1 + P2A);
    chk(np == 2, "R5 strobe count", np, 2);
    chk(lp == PH1 + PH2 - 1, "R6 latch index", lp, PH1 + PH2 - 1);
    chk(result == exp_res(a, b), "R7 result", int'(result), int'(exp_res(a, b)));
    chk(overrun == ovr_exp, "R8 overrun", int'(overrun), int'(ovr_exp));
    repeat (6) @(negedge clk);
    chk(result == exp_res(a, b), "R9 result held", int'(result), int'(exp_res(a, b)));
  endtask

  task automatic chk_reset_state();
    chk(busy_n && !smp_hold && !res_hold && !p1_strobe && !p2_strobe && !latch_upd,
        "R1 control idle", {busy_n, smp_hold, res_hold}, 3'b100);
    chk(!overrun && result == 16'h0, "R1 overrun/result", int'(result) + int'(overrun), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    chk_reset_state();
    convert(9'd0, 9'd0, 1'b0, 1'b0);       // R7 low clamp
    convert(9'd511, 9'd511, 1'b0, 1'b0);   // R7 high clamp
    convert(9'd256, 9'd128, 1'b0, 1'b0);   // R7 midscale
    convert(9'd1, 9'd0, 1'b0, 1'b0);       // R7 exact zero
    for (int i = 0; i < 12; i++) convert(9'($urandom), 9'($urandom), 1'b0, 1'b0);
    convert(9'($urandom), 9'($urandom), 1'b1, 1'b0);  // R8 ignored edge
    for (int i = 0; i < 4; i++) convert(9'($urandom), 9'($urandom), 1'b0, 1'b0);
    convert(9'd300, 9'd77, 1'b0, 1'b1);    // R2 level held
    repeat (3 * (PH1 + PH2)) begin
      @(negedge clk);
      if (!busy_n) break;
    end
    chk(busy_n == 1'b1, "R2 held level no restart", int'(busy_n), 1);
    start_async = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk_reset_state();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule